// File: doc/BRIEF.md
# Big-Endian Load/Store Aligner

This block sits between a 32-bit execution core and a word-wide data memory. The core presents a memory request with a base register value, a 16-bit displacement, an access size, a load/store direction and a signedness flag. The block forms the effective address by adding the sign-extended displacement to the base. A zero displacement gives a register-indirect access, and a zero base gives an absolute one. On stores it copies the source data onto every lane of the memory write bus and raises a byte strobe for each lane the access covers. Lanes use big-endian order, so address offset 0 is the most significant byte.

For loads, the memory returns the full word in the cycle after the request. The block remembers the lane offset, the size and the extension mode of each accepted load. In the return cycle it extracts the addressed byte or halfword and widens it to 32 bits, using sign or zero extension. A halfword or word that is not naturally aligned is rejected: the block flags the error and issues no memory access, no strobes and no load result.

Top module: `lsAligner`

## Requirements
- R1: `memAddr` equals `baseReg` plus `disp` sign-extended to 32 bits, modulo 2^32, in the same cycle as the request.
- R2: A byte store (`reqSize`=0) at offset k = `memAddr[1:0]` raises only strobe bit 3-k, where strobe bit 3 covers data bits [31:24]. `memWdata` holds `storeData[7:0]` copied into all four lanes.
- R3: A halfword store (`reqSize`=1) at offset 0 drives strobes 4'b1100 and at offset 2 drives 4'b0011. `memWdata` holds `storeData[15:0]` in both halves.
- R4: A word store (`reqSize`=2) at offset 0 drives strobes 4'b1111 and passes `storeData` through unchanged.
- R5: A signed byte load (`reqSize`=0, `reqUnsigned`=0) accepted in cycle t gives `loadValid`=1 in cycle t+1. In that cycle `loadData` is `memRdata[31-8k:24-8k]` sign-extended, where k is the offset.
- R6: An unsigned byte load (`reqUnsigned`=1) returns the same byte zero-extended in cycle t+1.
- R7: A halfword load returns `memRdata[31:16]` at offset 0 or `memRdata[15:0]` at offset 2 in cycle t+1. It is sign-extended when `reqUnsigned`=0 and zero-extended when `reqUnsigned`=1.
- R8: A word load returns `memRdata` unchanged in cycle t+1, whatever `reqUnsigned` holds.
- R9: A valid request is misaligned when it is a halfword with an odd offset, a word with a nonzero offset, or has the reserved size code 3. In that cycle the block drives `alignErr`=1 with `memReq`=0, `memWe`=0 and `memStrb`=0, and drives `loadValid`=0 in the next cycle.
- R10: While `rstN` is low, `loadValid` is 0. With `reqValid`=0, `memReq` and `alignErr` are both 0. A load never drives `memWe` or any strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqStore | input | 1 | 1 = store, 0 = load |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| reqUnsigned | input | 1 | Zero-extend a sub-word load |
| baseReg | input | 32 | Base register value |
| disp | input | 16 | Signed displacement |
| storeData | input | 32 | Store source, right-justified |
| memAddr | output | 32 | Effective byte address |
| memReq | output | 1 | Memory access issued |
| memWe | output | 1 | Memory write |
| memStrb | output | 4 | Byte write strobes, bit 3 = bits [31:24] |
| memWdata | output | 32 | Lane-replicated write data |
| memRdata | input | 32 | Word returned one cycle after a load |
| alignErr | output | 1 | Misaligned or reserved-size request |
| loadValid | output | 1 | `loadData` is valid this cycle |
| loadData | output | 32 | Extracted and extended load result |

## Verification
The bench builds the block with its default widths: 32-bit data, 32-bit address and 16-bit displacement. With those widths, every one of the four big-endian lane offsets can be reached. A negative displacement can carry the effective address down across the 2^31 boundary. Lane bytes whose top bit is set can tell sign extension apart from zero extension. A directed test sends back-to-back loads to show that the captured format of each load follows its own returned word.

// File: rtl/lsaPkg.sv
package lsaPkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } accSize_t;

  // strobes from control to datapath for the current request
  typedef struct packed {
    logic     issue;
    logic     write;
    logic     misaligned;
    accSize_t size;
  } reqCtrl_t;

  // format captured for a load in flight
  typedef struct packed {
    logic     zeroExt;
    accSize_t size;
  } ldCtrl_t;

endpackage

// File: rtl/lsaCtrl.sv
module lsaCtrl
  import lsaPkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqStore,
  input  logic [1:0]       reqSize,
  input  logic             reqUnsigned,
  input  logic [OFF_W-1:0] addrOff,
  output reqCtrl_t         reqC,
  output ldCtrl_t          ldC,
  output logic [OFF_W-1:0] ldOff,
  output logic             loadValid
);

  accSize_t sizeSel;
  logic     badAlign;
  logic     loadIssue;

  assign sizeSel = accSize_t'(reqSize);

  always_comb begin
    case (sizeSel)
      SZ_BYTE: badAlign = 1'b0;
      SZ_HALF: badAlign = addrOff[0];
      SZ_WORD: badAlign = |addrOff;
      default: badAlign = 1'b1;
    endcase
  end

  always_comb begin
    reqC.size       = sizeSel;
    reqC.misaligned = reqValid & badAlign;
    reqC.issue      = reqValid & ~badAlign;
    reqC.write      = reqValid & ~badAlign & reqStore;
  end

  assign loadIssue = reqValid & ~badAlign & ~reqStore;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadValid   <= 1'b0;
      ldC.size    <= SZ_WORD;
      ldC.zeroExt <= 1'b0;
      ldOff       <= '0;
    end else begin
      loadValid <= loadIssue;
      if (loadIssue) begin
        ldC.size    <= sizeSel;
        ldC.zeroExt <= reqUnsigned;
        ldOff       <= addrOff;
      end
    end
  end

  AST_LOAD_RETURNS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqStore && !reqC.misaligned) |=> loadValid); // R5

  AST_ERR_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    reqC.misaligned |=> !loadValid); // R9

  AST_FMT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !loadIssue |=> $stable(ldOff)); // R7

endmodule

// File: rtl/lsaData.sv
module lsaData
  import lsaPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  localparam int LANES  = DATA_W / 8,
  localparam int HALVES = LANES / 2,
  localparam int OFF_W  = $clog2(LANES)
) (
  input  logic [ADDR_W-1:0] baseReg,
  input  logic [DISP_W-1:0] disp,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] memRdata,
  input  reqCtrl_t          reqC,
  input  ldCtrl_t           ldC,
  input  logic [OFF_W-1:0]  ldOff,
  output logic [ADDR_W-1:0] effAddr,
  output logic [OFF_W-1:0]  addrOff,
  output logic [LANES-1:0]  memStrb,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] loadData
);

  logic [7:0]  selByte;
  logic [15:0] selHalf;

  assign effAddr = baseReg + {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
  assign addrOff = effAddr[OFF_W-1:0];

  // big-endian lanes: offset k drives strobe bit LANES-1-k
  genvar k;
  generate
    for (k = 0; k < LANES; k++) begin : gLane
      logic laneHit;
      always_comb begin
        case (reqC.size)
          SZ_BYTE: laneHit = (addrOff == OFF_W'(k));
          SZ_HALF: laneHit = (addrOff[OFF_W-1:1] == (OFF_W-1)'(k / 2));
          SZ_WORD: laneHit = 1'b1;
          default: laneHit = 1'b0;
        endcase
      end
      assign memStrb[LANES-1-k] = reqC.write & laneHit;
    end
  endgenerate

  always_comb begin
    case (reqC.size)
      SZ_BYTE: memWdata = {LANES{storeData[7:0]}};
      SZ_HALF: memWdata = {HALVES{storeData[15:0]}};
      default: memWdata = storeData;
    endcase
  end

  always_comb begin
    selByte = '0;
    for (int b = 0; b < LANES; b++)
      if (ldOff == OFF_W'(b)) selByte = memRdata[DATA_W-1-8*b -: 8];
  end

  always_comb begin
    selHalf = '0;
    for (int h = 0; h < HALVES; h++)
      if (ldOff[OFF_W-1:1] == (OFF_W-1)'(h)) selHalf = memRdata[DATA_W-1-16*h -: 16];
  end

  always_comb begin
    case (ldC.size)
      SZ_BYTE: loadData = {{(DATA_W-8){~ldC.zeroExt & selByte[7]}}, selByte};
      SZ_HALF: loadData = {{(DATA_W-16){~ldC.zeroExt & selHalf[15]}}, selHalf};
      default: loadData = memRdata;
    endcase
  end

endmodule

// File: rtl/lsAligner.sv
module lsAligner
  import lsaPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqStore,
  input  logic [1:0]        reqSize,
  input  logic              reqUnsigned,
  input  logic [ADDR_W-1:0] baseReg,
  input  logic [DISP_W-1:0] disp,
  input  logic [DATA_W-1:0] storeData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memReq,
  output logic              memWe,
  output logic [LANES-1:0]  memStrb,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              alignErr,
  output logic              loadValid,
  output logic [DATA_W-1:0] loadData
);

  reqCtrl_t         reqC;
  ldCtrl_t          ldC;
  logic [OFF_W-1:0] ldOff;
  logic [OFF_W-1:0] addrOff;

  lsaCtrl #(.OFF_W(OFF_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStore(reqStore),
    .reqSize(reqSize), .reqUnsigned(reqUnsigned), .addrOff(addrOff),
    .reqC(reqC), .ldC(ldC), .ldOff(ldOff), .loadValid(loadValid)
  );

  lsaData #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DISP_W(DISP_W)) uData (
    .baseReg(baseReg), .disp(disp), .storeData(storeData), .memRdata(memRdata),
    .reqC(reqC), .ldC(ldC), .ldOff(ldOff), .effAddr(memAddr), .addrOff(addrOff),
    .memStrb(memStrb), .memWdata(memWdata), .loadData(loadData)
  );

  assign memReq   = reqC.issue;
  assign memWe    = reqC.write;
  assign alignErr = reqC.misaligned;

  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |-> (!memReq && !memWe && memStrb == '0)); // R9

  AST_STRB_NEEDS_WE: assert property (@(posedge clk) disable iff (!rstN)
    (memStrb != '0) |-> memWe); // R10

  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && reqSize == 2'd0) |-> ($countones(memStrb) == 1)); // R2

  AST_HALF_TWO_LANES: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && reqSize == 2'd1) |-> ($countones(memStrb) == 2)); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!memReq && !alignErr)); // R10

endmodule

// File: tb/sim_lsAligner.sv
`timescale 1ns/1ps
module sim_lsAligner;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqStore = 1'b0, reqUnsigned = 1'b0;
  logic [1:0]  reqSize = 2'd0;
  logic [31:0] baseReg = '0, storeData = '0, memRdata = '0;
  logic [15:0] disp = '0;
  logic [31:0] memAddr, memWdata, loadData;
  logic        memReq, memWe, alignErr, loadValid;
  logic [3:0]  memStrb;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  lsAligner u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStore(reqStore),
    .reqSize(reqSize), .reqUnsigned(reqUnsigned), .baseReg(baseReg), .disp(disp),
    .storeData(storeData), .memAddr(memAddr), .memReq(memReq), .memWe(memWe),
    .memStrb(memStrb), .memWdata(memWdata), .memRdata(memRdata),
    .alignErr(alignErr), .loadValid(loadValid), .loadData(loadData)
  );

  typedef struct packed {
    logic        st;
    logic [1:0]  sz;
    logic        un;
    logic [31:0] base;
    logic [15:0] dsp;
    logic [31:0] data;
    logic [3:0]  strb;
    logic [31:0] out;
    logic        err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 1'b0, 32'h00001000, 16'h0003, 32'h000000A5, 4'b0001, 32'hA5A5A5A5, 1'b0, 4'd2}, // R2 off3
    '{1'b1, 2'd0, 1'b0, 32'h00002001, 16'hFFFF, 32'h12345677, 4'b1000, 32'h77777777, 1'b0, 4'd1}, // R1 negative disp
    '{1'b1, 2'd0, 1'b0, 32'h00000020, 16'h0001, 32'h000000C3, 4'b0100, 32'hC3C3C3C3, 1'b0, 4'd2}, // R2 off1
    '{1'b1, 2'd1, 1'b0, 32'h00000100, 16'h0002, 32'hDEADBEEF, 4'b0011, 32'hBEEFBEEF, 1'b0, 4'd3}, // R3 off2
    '{1'b1, 2'd1, 1'b0, 32'h00000104, 16'h0000, 32'h0000CAFE, 4'b1100, 32'hCAFECAFE, 1'b0, 4'd3}, // R3 off0
    '{1'b1, 2'd2, 1'b0, 32'h00000000, 16'h0040, 32'h89ABCDEF, 4'b1111, 32'h89ABCDEF, 1'b0, 4'd4}, // R4 absolute
    '{1'b0, 2'd0, 1'b0, 32'h00000300, 16'h0001, 32'h11F23344, 4'b0000, 32'hFFFFFFF2, 1'b0, 4'd5}, // R5
    '{1'b0, 2'd0, 1'b1, 32'h00000300, 16'h0001, 32'h11F23344, 4'b0000, 32'h000000F2, 1'b0, 4'd6}, // R6
    '{1'b0, 2'd0, 1'b0, 32'h00000303, 16'h0000, 32'h8000007F, 4'b0000, 32'h0000007F, 1'b0, 4'd5}, // R5 positive
    '{1'b0, 2'd0, 1'b1, 32'h00000302, 16'h0000, 32'h0000C300, 4'b0000, 32'h000000C3, 1'b0, 4'd6}, // R6 off2
    '{1'b0, 2'd1, 1'b0, 32'h00000400, 16'h0000, 32'h9ABC1234, 4'b0000, 32'hFFFF9ABC, 1'b0, 4'd7}, // R7 signed hi
    '{1'b0, 2'd1, 1'b1, 32'h00000400, 16'h0002, 32'h12348001, 4'b0000, 32'h00008001, 1'b0, 4'd7}, // R7 unsigned lo
    '{1'b0, 2'd1, 1'b0, 32'h00000402, 16'h0000, 32'hFFFF7FFF, 4'b0000, 32'h00007FFF, 1'b0, 4'd7}, // R7 positive lo
    '{1'b0, 2'd2, 1'b0, 32'h80000000, 16'h8000, 32'hA1B2C3D4, 4'b0000, 32'hA1B2C3D4, 1'b0, 4'd8}, // R8 wrap addr
    '{1'b0, 2'd2, 1'b1, 32'h00000010, 16'h0000, 32'h80000001, 4'b0000, 32'h80000001, 1'b0, 4'd8}, // R8 unsigned ignored
    '{1'b1, 2'd1, 1'b0, 32'h00000201, 16'h0000, 32'h00001111, 4'b0000, 32'h00000000, 1'b1, 4'd9}, // R9 half odd
    '{1'b1, 2'd2, 1'b0, 32'h00000200, 16'h0002, 32'h00000000, 4'b0000, 32'h00000000, 1'b1, 4'd9}, // R9 word off2
    '{1'b0, 2'd2, 1'b0, 32'h00000203, 16'h0000, 32'h00000000, 4'b0000, 32'h00000000, 1'b1, 4'd9}, // R9 word off3
    '{1'b0, 2'd3, 1'b0, 32'h00000200, 16'h0000, 32'h00000000, 4'b0000, 32'h00000000, 1'b1, 4'd9}, // R9 reserved size
    '{1'b0, 2'd1, 1'b1, 32'h00000500, 16'h0003, 32'h00000000, 4'b0000, 32'h00000000, 1'b1, 4'd9}  // R9 half off3
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // reset state (R10)
    repeat (2) @(negedge clk);
    chk("R10 reset loadValid", 32'(loadValid), 32'd0);
    chk("R10 reset memReq", 32'(memReq), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // idle with reserved size: no error, no request (R10)
    reqSize = 2'd3;
    baseReg = 32'h1;
    #1;
    chk("R10 idle alignErr", 32'(alignErr), 32'd0);
    chk("R10 idle memReq", 32'(memReq), 32'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tg;
      logic [31:0] expAddr;
      v = VECS[i];
      tg = $sformatf("R%0d vec%0d", v.req, i);
      @(negedge clk);
      reqValid = 1'b1;
      reqStore = v.st;
      reqSize = v.sz;
      reqUnsigned = v.un;
      baseReg = v.base;
      disp = v.dsp;
      storeData = v.st ? v.data : 32'h5A5A5A5A;
      memRdata = v.data;
      expAddr = v.base + {{16{v.dsp[15]}}, v.dsp};
      #1;
      chk({tg, " addr"}, memAddr, expAddr);
      chk({tg, " alignErr"}, 32'(alignErr), 32'(v.err));
      chk({tg, " memReq"}, 32'(memReq), 32'(!v.err));
      chk({tg, " memWe"}, 32'(memWe), 32'(v.st && !v.err));
      chk({tg, " strb"}, 32'(memStrb), 32'(v.strb));
      if (v.st && !v.err) chk({tg, " wdata"}, memWdata, v.out);
      @(negedge clk);
      reqValid = 1'b0;
      #1;
      chk({tg, " loadValid"}, 32'(loadValid), 32'(!v.st && !v.err));
      if (!v.st && !v.err) chk({tg, " loadData"}, loadData, v.out);
    end

    // back-to-back loads keep their own formats (R5, R6)
    @(negedge clk);
    reqValid = 1'b1; reqStore = 1'b0; reqSize = 2'd0; reqUnsigned = 1'b0;
    baseReg = 32'h600; disp = 16'h0000;
    @(negedge clk);
    reqUnsigned = 1'b1; disp = 16'h0001;
    memRdata = 32'h80FF0000;
    #1;
    chk("R5 b2b first loadValid", 32'(loadValid), 32'd1);
    chk("R5 b2b first loadData", loadData, 32'hFFFFFF80);
    @(negedge clk);
    reqValid = 1'b0;
    memRdata = 32'h00AB0000;
    #1;
    chk("R6 b2b second loadValid", 32'(loadValid), 32'd1);
    chk("R6 b2b second loadData", loadData, 32'h000000AB);
    @(negedge clk);
    #1;
    chk("R10 after b2b loadValid", 32'(loadValid), 32'd0);

    // reset while a load is pending clears the result (R10)
    reqValid = 1'b1; reqSize = 2'd2; baseReg = 32'h700; disp = 16'h0;
    @(negedge clk);
    reqValid = 1'b0;
    rstN = 1'b0;
    #1;
    chk("R10 reset clears loadValid", 32'(loadValid), 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    finishRun();
  end

endmodule